// File: doc/BRIEF.md
# Tiled Error-Correction Micro-Op Issuer

This block feeds one small control code per qubit, every clock cycle, to an array of qubits laid out as identical tiles of four neighbours. A short error-correction program describing a single tile is held in a local store. Once the engine is started it steps through that program without end, and each entry is copied to every tile at once. The storage therefore depends only on the program length, not on how many tiles are attached. A parameter-time guard keeps the store at or below 4096 bits.

A second path takes logical instructions from a master controller through a valid/ready handshake. Each one names a qubit and an operation, and is turned into a micro-op code for that single qubit. A per-qubit mask chooses, every cycle, whether a qubit listens to the repeating error-correction stream (mask 0) or to the logical path (mask 1). A qubit on the logical path that receives no operation is given the idle code 0.

The engine state machine has two states, `ENG_HALT` and `ENG_RUN`. `start` moves HALT to RUN when `run_i` is high. `stop` moves RUN to HALT when `run_i` is low. `loop` keeps RUN while `run_i` stays high. The logical path has two states, `LG_OPEN` and `LG_HOLD`. `accept` moves OPEN to HOLD on valid with ready. `issue` always moves HOLD back to OPEN after one cycle.

Top module: `tile_uop_issuer`

## Requirements
- R1: After reset the engine is halted, every `uop_o` lane is 0, `li_ready_o` is 1, `cfg_err_o` is 0, and the mask is all zeros.
- R2: While running, lane q carries bits [p*C +: C] of the current program entry, with p = q mod 4. Every tile shows the same codes at the same time.
- R3: The first running cycle after `start` shows entry 0. The entry index then rises by one per cycle and goes back to 0 after the loaded last address.
- R4: While halted, lanes on the error-correction path output 0. `stop` resets the entry index, so the next `start` begins at entry 0.
- R5: Program-entry and last-address writes take effect only while halted. A write attempted while running changes nothing, and `cfg_err_o` is 1 for exactly the following cycle.
- R6: `li_ready_o` is 1 whenever no logical micro-op is held. An instruction is taken on valid and ready, and `li_ready_o` is 0 in the cycle after that.
- R7: In the cycle after acceptance, the target qubit outputs `li_op_i` if its mask bit is 1. Op value 0 issues the idle code.
- R8: If the target's mask bit is 0, the logical micro-op is dropped and that qubit keeps its error-correction code.
- R9: A qubit with mask bit 1 and no logical micro-op aimed at it in that cycle outputs 0, whether running or halted.
- R10: A mask write replaces the whole mask and takes effect in the following cycle, whether running or halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_i | input | 1 | High to run the error-correction loop, low to halt it |
| ucode_we_i | input | 1 | Program entry write strobe |
| ucode_addr_i | input | $clog2(DEPTH) | Program entry address |
| ucode_data_i | input | 4*CODE_W | Entry: one code per position in the tile |
| len_we_i | input | 1 | Last-address write strobe |
| len_last_i | input | $clog2(DEPTH) | Last program address before wrap |
| cfg_err_o | output | 1 | One-cycle flag for a rejected configuration write |
| mask_we_i | input | 1 | Mask write strobe |
| mask_i | input | NUM_TILES*4 | New mask, 1 selects the logical path |
| li_valid_i | input | 1 | Logical instruction valid |
| li_ready_o | output | 1 | Logical instruction ready |
| li_op_i | input | CODE_W | Logical operation code |
| li_qubit_i | input | $clog2(NUM_TILES*4) | Target qubit index |
| uop_o | output | NUM_TILES*4*CODE_W | Per-qubit micro-op codes, qubit q at [q*CODE_W +: CODE_W] |

## Verification
The program store is filled with entries whose codes differ at every tile position and address. Comparing every lane each cycle against an arithmetic model separates a wrong field position, a wrong tile copy and an off-by-one loop. Two loop lengths, rejected writes made in mid-run, and a stop followed by a restart tell apart wrap, gating and index-reset faults. Every qubit is then targeted under a mask and under its complement, and a held-high valid is used. This separates issue to the wrong qubit, issue through a mask-0 lane, a late issue and a ready that never drops.

// File: rtl/tile_uop_pkg.sv
package tile_uop_pkg;

    typedef enum logic {
        ENG_HALT = 1'b0,
        ENG_RUN  = 1'b1
    } eng_state_e;

    typedef enum logic {
        LG_OPEN = 1'b0,
        LG_HOLD = 1'b1
    } lg_state_e;

    localparam int unsigned CELL_QUBITS    = 4;
    localparam int unsigned STORE_BUDGET_B = 4096;

endpackage

// File: rtl/uc_store.sv
module uc_store
    import tile_uop_pkg::*;
#(
    parameter int unsigned CODE_W = 3,
    parameter int unsigned DEPTH  = 16,
    localparam int unsigned AW    = $clog2(DEPTH),
    localparam int unsigned EW    = CELL_QUBITS * CODE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          halted_i,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [EW-1:0] wr_data_i,
    input  logic          len_en_i,
    input  logic [AW-1:0] len_last_i,
    input  logic [AW-1:0] rd_addr_i,
    output logic [EW-1:0] rd_entry_o,
    output logic [AW-1:0] last_o,
    output logic          reject_o
);

    logic [EW-1:0] mem_q [DEPTH];
    logic [AW-1:0] last_q;
    logic          reject_q;
    logic          wr_ok;
    logic          len_ok;

    assign wr_ok  = wr_en_i  && halted_i;
    assign len_ok = len_en_i && halted_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(DEPTH); i++) begin
                mem_q[i] <= '0;
            end
        end else if (wr_ok) begin
            mem_q[wr_addr_i] <= wr_data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q   <= '0;
            reject_q <= 1'b0;
        end else begin
            if (len_ok) begin
                last_q <= len_last_i;
            end
            reject_q <= !halted_i && (wr_en_i || len_en_i);
        end
    end

    assign rd_entry_o = mem_q[rd_addr_i];
    assign last_o     = last_q;
    assign reject_o   = reject_q;

endmodule

// File: rtl/ecc_sequencer.sv
module ecc_sequencer
    import tile_uop_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic [AW-1:0] last_i,
    output logic          running_o,
    output logic [AW-1:0] pc_o
);

    eng_state_e    state_q, state_d;
    logic [AW-1:0] pc_q, pc_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ENG_HALT;
            pc_q    <= '0;
        end else begin
            state_q <= state_d;
            pc_q    <= pc_d;
        end
    end

    always_comb begin
        state_d = state_q;
        pc_d    = pc_q;
        unique case (state_q)
            ENG_HALT: begin
                pc_d = '0;
                if (run_i) begin
                    state_d = ENG_RUN;
                end
            end
            ENG_RUN: begin
                if (!run_i) begin
                    state_d = ENG_HALT;
                    pc_d    = '0;
                end else if (pc_q == last_i) begin
                    pc_d = '0;
                end else begin
                    pc_d = pc_q + 1'b1;
                end
            end
            default: begin
                state_d = ENG_HALT;
                pc_d    = '0;
            end
        endcase
    end

    always_comb begin
        running_o = 1'b0;
        unique case (state_q)
            ENG_HALT: running_o = 1'b0;
            ENG_RUN:  running_o = 1'b1;
            default:  running_o = 1'b0;
        endcase
    end

    assign pc_o = pc_q;

endmodule

// File: rtl/logical_decoder.sv
module logical_decoder
    import tile_uop_pkg::*;
#(
    parameter int unsigned CODE_W = 3,
    parameter int unsigned NQ     = 16,
    localparam int unsigned QW    = $clog2(NQ)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [CODE_W-1:0] op_i,
    input  logic [QW-1:0]     qubit_i,
    output logic              ready_o,
    output logic              issue_v_o,
    output logic [QW-1:0]     issue_q_o,
    output logic [CODE_W-1:0] issue_code_o
);

    lg_state_e         state_q, state_d;
    logic [QW-1:0]     tgt_q;
    logic [CODE_W-1:0] code_q;
    logic              take;

    function automatic logic [CODE_W-1:0] decode_op(input logic [CODE_W-1:0] op);
        logic [CODE_W-1:0] code;
        code = '0;
        if (op != '0) begin
            code = op;
        end
        return code;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LG_OPEN;
            tgt_q   <= '0;
            code_q  <= '0;
        end else begin
            state_q <= state_d;
            if (take) begin
                tgt_q  <= qubit_i;
                code_q <= decode_op(op_i);
            end
        end
    end

    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        unique case (state_q)
            LG_OPEN: begin
                if (valid_i) begin
                    take    = 1'b1;
                    state_d = LG_HOLD;
                end
            end
            LG_HOLD: state_d = LG_OPEN;
            default: state_d = LG_OPEN;
        endcase
    end

    always_comb begin
        ready_o   = 1'b0;
        issue_v_o = 1'b0;
        unique case (state_q)
            LG_OPEN: ready_o   = 1'b1;
            LG_HOLD: issue_v_o = 1'b1;
            default: ready_o   = 1'b0;
        endcase
    end

    assign issue_q_o    = tgt_q;
    assign issue_code_o = code_q;

endmodule

// File: rtl/lane_mux.sv
module lane_mux
    import tile_uop_pkg::*;
#(
    parameter int unsigned CODE_W    = 3,
    parameter int unsigned NUM_TILES = 4,
    localparam int unsigned NQ       = NUM_TILES * CELL_QUBITS,
    localparam int unsigned QW       = $clog2(NQ),
    localparam int unsigned EW       = CELL_QUBITS * CODE_W
) (
    input  logic              running_i,
    input  logic [EW-1:0]     entry_i,
    input  logic [NQ-1:0]     mask_i,
    input  logic              issue_v_i,
    input  logic [QW-1:0]     issue_q_i,
    input  logic [CODE_W-1:0] issue_code_i,
    output logic [NQ*CODE_W-1:0] uop_o
);

    for (genvar t = 0; t < int'(NUM_TILES); t++) begin : g_tile
        for (genvar p = 0; p < int'(CELL_QUBITS); p++) begin : g_pos
            localparam int unsigned Q = t * CELL_QUBITS + p;
            logic [CODE_W-1:0] ecc_code;
            logic [CODE_W-1:0] log_code;
            logic              hit;

            assign hit      = issue_v_i && (issue_q_i == QW'(Q));
            assign ecc_code = running_i ? entry_i[p*CODE_W +: CODE_W] : '0;
            assign log_code = hit ? issue_code_i : '0;
            assign uop_o[Q*CODE_W +: CODE_W] = mask_i[Q] ? log_code : ecc_code;
        end
    end

endmodule

// File: rtl/tile_uop_issuer.sv
module tile_uop_issuer
    import tile_uop_pkg::*;
#(
    parameter int unsigned NUM_TILES = 4,
    parameter int unsigned CODE_W    = 3,
    parameter int unsigned DEPTH     = 16,
    localparam int unsigned NQ       = NUM_TILES * CELL_QUBITS,
    localparam int unsigned QW       = $clog2(NQ),
    localparam int unsigned AW       = $clog2(DEPTH),
    localparam int unsigned EW       = CELL_QUBITS * CODE_W,
    localparam int unsigned STORE_B  = DEPTH * EW + AW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run_i,
    input  logic                 ucode_we_i,
    input  logic [AW-1:0]        ucode_addr_i,
    input  logic [EW-1:0]        ucode_data_i,
    input  logic                 len_we_i,
    input  logic [AW-1:0]        len_last_i,
    output logic                 cfg_err_o,
    input  logic                 mask_we_i,
    input  logic [NQ-1:0]        mask_i,
    input  logic                 li_valid_i,
    output logic                 li_ready_o,
    input  logic [CODE_W-1:0]    li_op_i,
    input  logic [QW-1:0]        li_qubit_i,
    output logic [NQ*CODE_W-1:0] uop_o
);

    if (STORE_B > STORE_BUDGET_B) begin : g_budget
        $error("microcode store exceeds its bit budget");
    end

    logic              eng_running;
    logic [AW-1:0]     pc;
    logic [AW-1:0]     cfg_last;
    logic [EW-1:0]     cur_entry;
    logic [NQ-1:0]     mask_q;
    logic              iss_v;
    logic [QW-1:0]     iss_q;
    logic [CODE_W-1:0] iss_code;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (mask_we_i) begin
            mask_q <= mask_i;
        end
    end

    uc_store #(.CODE_W(CODE_W), .DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .halted_i   (!eng_running),
        .wr_en_i    (ucode_we_i),
        .wr_addr_i  (ucode_addr_i),
        .wr_data_i  (ucode_data_i),
        .len_en_i   (len_we_i),
        .len_last_i (len_last_i),
        .rd_addr_i  (pc),
        .rd_entry_o (cur_entry),
        .last_o     (cfg_last),
        .reject_o   (cfg_err_o)
    );

    ecc_sequencer #(.DEPTH(DEPTH)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run_i),
        .last_i    (cfg_last),
        .running_o (eng_running),
        .pc_o      (pc)
    );

    logical_decoder #(.CODE_W(CODE_W), .NQ(NQ)) u_dec (
        .clk          (clk),
        .rst_n        (rst_n),
        .valid_i      (li_valid_i),
        .op_i         (li_op_i),
        .qubit_i      (li_qubit_i),
        .ready_o      (li_ready_o),
        .issue_v_o    (iss_v),
        .issue_q_o    (iss_q),
        .issue_code_o (iss_code)
    );

    lane_mux #(.CODE_W(CODE_W), .NUM_TILES(NUM_TILES)) u_mux (
        .running_i    (eng_running),
        .entry_i      (cur_entry),
        .mask_i       (mask_q),
        .issue_v_i    (iss_v),
        .issue_q_i    (iss_q),
        .issue_code_i (iss_code),
        .uop_o        (uop_o)
    );

endmodule

// File: rtl/tile_uop_issuer_chk.sv
module tile_uop_issuer_chk #(
    parameter int unsigned NQ     = 16,
    parameter int unsigned CODE_W = 3,
    parameter int unsigned AW     = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 run_i,
    input logic                 ucode_we_i,
    input logic                 len_we_i,
    input logic                 cfg_err_o,
    input logic                 li_valid_i,
    input logic                 li_ready_o,
    input logic [NQ*CODE_W-1:0] uop_o,
    input logic                 eng_running,
    input logic [AW-1:0]        pc,
    input logic [AW-1:0]        cfg_last,
    input logic [NQ-1:0]        mask_q,
    input logic                 iss_v
);

    logic [NQ*CODE_W-1:0] logical_lanes;

    always_comb begin
        for (int q = 0; q < int'(NQ); q++) begin
            logical_lanes[q*CODE_W +: CODE_W] = mask_q[q] ? uop_o[q*CODE_W +: CODE_W] : '0;
        end
    end

    // R6
    ready_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (li_valid_i && li_ready_o) |=> !li_ready_o);

    // R5
    reject_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_running && (ucode_we_i || len_we_i)) |=> cfg_err_o);

    // R5
    len_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_running && len_we_i) |=> $stable(cfg_last));

    // R3
    pc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_running && run_i && pc == cfg_last) |=> (pc == '0));

    // R4
    halted_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!eng_running && !iss_v) |-> (uop_o == '0));

    // R9
    idle_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !iss_v |-> (logical_lanes == '0));

    // R4
    start_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eng_running) |-> (pc == '0));

endmodule

bind tile_uop_issuer tile_uop_issuer_chk #(
    .NQ(NQ), .CODE_W(CODE_W), .AW(AW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_i       (run_i),
    .ucode_we_i  (ucode_we_i),
    .len_we_i    (len_we_i),
    .cfg_err_o   (cfg_err_o),
    .li_valid_i  (li_valid_i),
    .li_ready_o  (li_ready_o),
    .uop_o       (uop_o),
    .eng_running (eng_running),
    .pc          (pc),
    .cfg_last    (cfg_last),
    .mask_q      (mask_q),
    .iss_v       (iss_v)
);

// File: tb/tile_uop_issuer_bench.sv
module tile_uop_issuer_bench;

    localparam int NT = 2;
    localparam int CW = 3;
    localparam int DP = 8;
    localparam int NQ = NT * 4;
    localparam int AW = 3;
    localparam int QW = 3;
    localparam int EW = 4 * CW;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             run_i = 1'b0;
    logic             ucode_we = 1'b0;
    logic [AW-1:0]    ucode_addr = '0;
    logic [EW-1:0]    ucode_data = '0;
    logic             len_we = 1'b0;
    logic [AW-1:0]    len_last = '0;
    logic             cfg_err;
    logic             mask_we = 1'b0;
    logic [NQ-1:0]    mask_d = '0;
    logic             li_valid = 1'b0;
    logic             li_ready;
    logic [CW-1:0]    li_op = '0;
    logic [QW-1:0]    li_qubit = '0;
    logic [NQ*CW-1:0] uop;

    always #5 clk = ~clk;

    tile_uop_issuer #(.NUM_TILES(NT), .CODE_W(CW), .DEPTH(DP)) u_tile_uop_issuer (
        .clk(clk), .rst_n(rst_n), .run_i(run_i),
        .ucode_we_i(ucode_we), .ucode_addr_i(ucode_addr), .ucode_data_i(ucode_data),
        .len_we_i(len_we), .len_last_i(len_last), .cfg_err_o(cfg_err),
        .mask_we_i(mask_we), .mask_i(mask_d),
        .li_valid_i(li_valid), .li_ready_o(li_ready), .li_op_i(li_op), .li_qubit_i(li_qubit),
        .uop_o(uop)
    );

    int checks = 0;
    int errs   = 0;
    bit done   = 0;

    logic [EW-1:0] m_mem [DP];
    int            m_last = 0;
    int            m_pc   = 0;
    bit            m_run  = 0;
    bit            m_err  = 0;
    bit            m_pv   = 0;
    int            m_pq   = 0;
    int            m_pop  = 0;
    logic [NQ-1:0] m_mask = '0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [EW-1:0] pattern(input int e, input int salt);
        logic [EW-1:0] v;
        for (int p = 0; p < 4; p++) begin
            v[p*CW +: CW] = CW'((e * 3 + p * 5 + 1 + salt) % 8);
        end
        return v;
    endfunction

    function automatic logic [NQ*CW-1:0] expect_uops();
        logic [NQ*CW-1:0] v;
        for (int q = 0; q < NQ; q++) begin
            if (m_mask[q]) begin
                v[q*CW +: CW] = (m_pv && m_pq == q) ? CW'(m_pop) : '0;
            end else begin
                v[q*CW +: CW] = m_run ? m_mem[m_pc][(q % 4)*CW +: CW] : '0;
            end
        end
        return v;
    endfunction

    task automatic tick(input string tag);
        @(posedge clk);
        m_err = m_run && (ucode_we || len_we);
        if (!m_run) begin
            if (ucode_we) m_mem[ucode_addr] = ucode_data;
            if (len_we)   m_last = int'(len_last);
        end
        if (mask_we) m_mask = mask_d;
        if (m_pv) begin
            m_pv = 0;
        end else if (li_valid) begin
            m_pv  = 1;
            m_pq  = int'(li_qubit);
            m_pop = int'(li_op);
        end
        if (!m_run && run_i) begin
            m_run = 1; m_pc = 0;
        end else if (m_run && !run_i) begin
            m_run = 0; m_pc = 0;
        end else if (m_run) begin
            m_pc = (m_pc == m_last) ? 0 : m_pc + 1;
        end
        #2;
        chk(tag, 64'(uop), 64'(expect_uops()));
        chk("R6 ready", 64'(li_ready), 64'(!m_pv));
        chk("R5 cfg_err", 64'(cfg_err), 64'(m_err));
        ucode_we = 0; len_we = 0; mask_we = 0; li_valid = 0;
    endtask

    initial begin
        for (int i = 0; i < DP; i++) m_mem[i] = '0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        chk("R1 uop", 64'(uop), 64'd0);
        chk("R1 ready", 64'(li_ready), 64'd1);
        chk("R1 cfg_err", 64'(cfg_err), 64'd0);
        tick("R1");

        for (int e = 0; e < DP; e++) begin
            ucode_we = 1; ucode_addr = AW'(e); ucode_data = pattern(e, 0);
            tick("R4 halted load");
        end
        len_we = 1; len_last = 3'd4;
        tick("R4 halted load");

        run_i = 1'b1;
        for (int k = 0; k < 12; k++) tick((k < 6) ? "R2" : "R3");

        ucode_we = 1; ucode_addr = 3'd1; ucode_data = pattern(1, 3);
        tick("R5 rejected entry");
        len_we = 1; len_last = 3'd7;
        tick("R5 rejected length");
        for (int k = 0; k < 6; k++) tick("R5 unchanged");

        run_i = 1'b0;
        for (int k = 0; k < 3; k++) tick("R4");
        len_we = 1; len_last = 3'd1;
        tick("R5 halted length");
        run_i = 1'b1;
        for (int k = 0; k < 6; k++) tick("R3 short loop");

        mask_we = 1; mask_d = 8'b1010_0110;
        tick("R10");
        for (int k = 0; k < 3; k++) tick("R9");

        for (int pass = 0; pass < 2; pass++) begin
            if (pass == 1) begin
                mask_we = 1; mask_d = ~m_mask;
                tick("R10");
            end
            for (int q = 0; q < NQ; q++) begin
                li_valid = 1; li_qubit = QW'(q); li_op = CW'((q + pass) % 8);
                tick("R6 accept");
                tick(m_mask[q] ? "R7" : "R8");
            end
        end

        for (int k = 0; k < 8; k++) begin
            li_valid = 1; li_qubit = QW'(k); li_op = CW'(7 - (k % 7));
            tick("R6 held valid");
        end

        run_i = 1'b0;
        li_valid = 1; li_qubit = 3'd1; li_op = 3'd5;
        tick("R9 halted");
        tick("R9 halted issue");
        tick("R9 halted");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule